// File: doc/BRIEF.md
# Dual-Lane Bitfield Address Generator

This block speeds up table-driven encoding loops by turning one packed data word into two lookup-table addresses without any processor shift or mask instructions. Software stores a packed word, for example two 16-bit pixels or four 8-bit pixels, into a shared accumulator register. Each of two lanes then shifts that word right, keeps a configurable window of bits and adds its own base address. Software reads the two sums back as ready-to-use pointers.

Each lane has three 5-bit fields: a right-shift amount, a low bit index and a high bit index. The low and high indices bound the mask, and the mask is applied after the shift. The shifter only moves bits right. Any scaling up to the size of a table entry must therefore be done before the word is stored. Both lane results are read through peek locations. These are computed directly from the current register contents, so reading them never changes any state. When one instance serves pixels 0 and 1 of a word, a second instance can serve pixels 2 and 3 of the same word.

The register bus has one write port and one independent read port, both addressed by word index. A write takes effect at the clock edge. A read returns its data in the same cycle.

Top module: `bfag_top`

## Requirements
- R1: After reset every readable location returns 0: the accumulator, both control words, both bases and both peek results.
- R2: A write to address 0 loads the accumulator. Reading address 0 in any later cycle returns the written word.
- R3: Lane control words are at address 1 (lane 0) and address 2 (lane 1). Bits [4:0] hold the right-shift amount, bits [9:5] the mask low index and bits [14:10] the mask high index. Bits [31:15] are discarded on write and read as 0.
- R4: Lane base addresses are at address 3 (lane 0) and address 4 (lane 1). They are full 32-bit read/write registers.
- R5: Address 5 returns lane 0's result and address 6 returns lane 1's result. Each result is base + ((accumulator >> shift) AND mask), where the mask has ones exactly at bit positions low..high inclusive. The two lanes work independently on the same accumulator.
- R6: The shift is a logical right shift only. Bits moved below bit 0 are lost and zeros enter from the top; nothing wraps around.
- R7: When the mask high index is below the mask low index, the mask is empty and the lane result equals its base.
- R8: Reading a peek location has no side effect. Repeated reads with no write in between return the same value, and all other registers keep their values.
- R9: A peek read in the same cycle as an accumulator write returns the result for the old accumulator. A peek read in the following cycle returns the result for the new word.
- R10: Writes to addresses 5, 6 and 7 change nothing. A read from address 7 returns 0.
- R11: The base addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the current cycle |
| bus_wr_addr | input | 3 | Word index of the write |
| bus_wdata | input | 32 | Write data |
| bus_rd_addr | input | 3 | Word index of the read |
| bus_rdata | output | 32 | Read data, combinational from bus_rd_addr |

## Verification
The read and write ports are separate, so an accumulator update and a peek read can fall in the same cycle. The bench drives exactly that pair: it stores a word while pointing the read port at a lane result. It samples the read data before the clock edge and expects the result for the previous word. It samples again one cycle later and expects the result for the new word. Random mixes of writes and reads repeat this overlap many times, and every read is compared against a model built from the register description.

// File: rtl/bfag_pkg.sv
package bfag_pkg;

   // Kinds of location in the word-indexed register map
   typedef enum logic [2:0] {
      RG_ACC,
      RG_CTRL,
      RG_BASE,
      RG_PEEK,
      RG_NONE
   } region_e;

   // Map a word index onto its region for a given lane count
   function automatic region_e region_of(input int unsigned a, input int unsigned n);
      if (a == 0)            return RG_ACC;
      else if (a <= n)       return RG_CTRL;
      else if (a <= 2 * n)   return RG_BASE;
      else if (a <= 3 * n)   return RG_PEEK;
      else                   return RG_NONE;
   endfunction

   // Lane number inside a per-lane region
   function automatic int unsigned lane_of(input int unsigned a, input int unsigned n);
      if (a == 0) return 0;
      return (a - 1) % n;
   endfunction

endpackage

// File: rtl/bfag_regs.sv
module bfag_regs #(
   parameter int DATA_W = 32,
   parameter int SH_W   = 5,
   parameter int LANES  = 2,
   parameter int ADDR_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         acc_q,
   output logic [LANES*3*SH_W-1:0]   ctrl_flat,
   output logic [LANES*DATA_W-1:0]   base_flat
);
   localparam int CTRL_W = 3 * SH_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (wr_en && wr_addr == '0)
         acc_q <= wdata;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane_regs
      localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(1 + l);
      localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(1 + LANES + l);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_flat[l*CTRL_W +: CTRL_W] <= '0;
         else if (wr_en && wr_addr == CTRL_A)
            ctrl_flat[l*CTRL_W +: CTRL_W] <= wdata[CTRL_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_flat[l*DATA_W +: DATA_W] <= '0;
         else if (wr_en && wr_addr == BASE_A)
            base_flat[l*DATA_W +: DATA_W] <= wdata;
      end
   end
endmodule

// File: rtl/bfag_lane.sv
module bfag_lane #(
   parameter int DATA_W   = 32,
   parameter int SH_W     = 5,
   parameter bit MASK_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [3*SH_W-1:0] ctrl,
   input  logic [DATA_W-1:0] base,
   output logic [DATA_W-1:0] res
);
   logic [SH_W-1:0]   sh_amt;
   logic [SH_W-1:0]   lo_idx;
   logic [SH_W-1:0]   hi_idx;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] field_mask;

   assign sh_amt  = ctrl[SH_W-1:0];
   assign lo_idx  = ctrl[2*SH_W-1:SH_W];
   assign hi_idx  = ctrl[3*SH_W-1:2*SH_W];
   assign shifted = acc >> sh_amt;

   if (MASK_CMP) begin : g_mask_cmp
      // One pair of magnitude compares per bit: shallow, wide
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign field_mask[i] = (SH_W'(i) >= lo_idx) && (SH_W'(i) <= hi_idx);
      end
   end else begin : g_mask_shift
      // Two barrel shifts of an all-ones word: narrow, deeper
      logic [DATA_W-1:0] ones;
      logic [DATA_W-1:0] upto_hi;
      logic [DATA_W-1:0] from_lo;
      assign ones    = '1;
      assign upto_hi = ones >> (SH_W'(DATA_W - 1) - hi_idx);
      assign from_lo = ones << lo_idx;
      assign field_mask = upto_hi & from_lo;
   end

   assign res = base + (shifted & field_mask);
endmodule

// File: rtl/bfag_rdmux.sv
module bfag_rdmux
   import bfag_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SH_W   = 5,
   parameter int LANES  = 2,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [DATA_W-1:0]       acc_q,
   input  logic [LANES*3*SH_W-1:0] ctrl_flat,
   input  logic [LANES*DATA_W-1:0] base_flat,
   input  logic [LANES*DATA_W-1:0] res_flat,
   output logic [DATA_W-1:0]       rdata
);
   localparam int CTRL_W = 3 * SH_W;

   region_e     rg;
   int unsigned ln;

   always_comb begin
      rg    = region_of(int'(rd_addr), LANES);
      ln    = lane_of(int'(rd_addr), LANES);
      rdata = '0;
      unique case (rg)
         RG_ACC:  rdata = acc_q;
         RG_CTRL: rdata = DATA_W'(ctrl_flat[ln*CTRL_W +: CTRL_W]);
         RG_BASE: rdata = base_flat[ln*DATA_W +: DATA_W];
         RG_PEEK: rdata = res_flat[ln*DATA_W +: DATA_W];
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/bfag_top.sv
module bfag_top #(
   parameter int DATA_W   = 32,
   parameter int LANES    = 2,
   parameter int ADDR_W   = 3,
   parameter bit MASK_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_wr_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ADDR_W-1:0] bus_rd_addr,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int SH_W   = $clog2(DATA_W);
   localparam int CTRL_W = 3 * SH_W;
   localparam int N_LOC  = 3 * LANES + 1;

   if (DATA_W != (1 << SH_W) || DATA_W < 8) begin : g_bad_width
      $error("bfag_top: DATA_W must be a power of two of at least 8");
   end
   if (N_LOC > (1 << ADDR_W)) begin : g_bad_addr
      $error("bfag_top: ADDR_W too small for the register map");
   end
   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("bfag_top: control fields do not fit in one word");
   end

   logic [DATA_W-1:0]       acc_q;
   logic [LANES*CTRL_W-1:0] ctrl_flat;
   logic [LANES*DATA_W-1:0] base_flat;
   logic [LANES*DATA_W-1:0] res_flat;

   bfag_regs #(
      .DATA_W(DATA_W), .SH_W(SH_W), .LANES(LANES), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr_en),
      .wr_addr  (bus_wr_addr),
      .wdata    (bus_wdata),
      .acc_q    (acc_q),
      .ctrl_flat(ctrl_flat),
      .base_flat(base_flat)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      bfag_lane #(
         .DATA_W(DATA_W), .SH_W(SH_W), .MASK_CMP(MASK_CMP)
      ) u_lane (
         .acc (acc_q),
         .ctrl(ctrl_flat[l*CTRL_W +: CTRL_W]),
         .base(base_flat[l*DATA_W +: DATA_W]),
         .res (res_flat[l*DATA_W +: DATA_W])
      );
   end

   bfag_rdmux #(
      .DATA_W(DATA_W), .SH_W(SH_W), .LANES(LANES), .ADDR_W(ADDR_W)
   ) u_rdmux (
      .rd_addr  (bus_rd_addr),
      .acc_q    (acc_q),
      .ctrl_flat(ctrl_flat),
      .base_flat(base_flat),
      .res_flat (res_flat),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/bfag_chk.sv
module bfag_chk #(
   parameter int DATA_W = 32,
   parameter int LANES  = 2,
   parameter int ADDR_W = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic [DATA_W-1:0]         wdata,
   input logic [ADDR_W-1:0]         rd_addr,
   input logic [DATA_W-1:0]         rdata,
   input logic [LANES*3*$clog2(DATA_W)-1:0] ctrl_flat,
   input logic [LANES*DATA_W-1:0]   base_flat,
   input logic [LANES*DATA_W-1:0]   res_flat
);
   localparam int SH_W   = $clog2(DATA_W);
   localparam int CTRL_W = 3 * SH_W;
   localparam int PK_LO  = 2 * LANES + 1;
   localparam int PK_HI  = 3 * LANES;

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> rdata == '0);

   // R2
   acc_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && wr_addr == '0) && rd_addr == '0) |-> rdata == $past(wdata));

   // R8
   peek_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && rd_addr == $past(rd_addr) &&
       int'(rd_addr) >= PK_LO && int'(rd_addr) <= PK_HI) |-> $stable(rdata));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) > PK_HI) |-> rdata == '0);

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      // R7
      empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_flat[l*CTRL_W + 2*SH_W +: SH_W] < ctrl_flat[l*CTRL_W + SH_W +: SH_W])
         |-> res_flat[l*DATA_W +: DATA_W] == base_flat[l*DATA_W +: DATA_W]);
   end
endmodule

bind bfag_top bfag_chk #(
   .DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (bus_wr_en),
   .wr_addr  (bus_wr_addr),
   .wdata    (bus_wdata),
   .rd_addr  (bus_rd_addr),
   .rdata    (bus_rdata),
   .ctrl_flat(ctrl_flat),
   .base_flat(base_flat),
   .res_flat (res_flat)
);

// File: tb/sim_bfag_top.sv
`timescale 1ns/1ps
module sim_bfag_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wdata = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench model of the registers
   logic [31:0] m_acc;
   logic [14:0] m_ctrl [2];
   logic [31:0] m_base [2];

   always #4 clk = ~clk;

   bfag_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_wr_addr(wr_addr),
      .bus_wdata(wdata), .bus_rd_addr(rd_addr), .bus_rdata(rdata)
   );

   function automatic logic [31:0] exp_peek(input int l);
      logic [31:0] v;
      logic [31:0] f;
      int sh, lo, hi;
      sh = int'(m_ctrl[l][4:0]);
      lo = int'(m_ctrl[l][9:5]);
      hi = int'(m_ctrl[l][14:10]);
      v = m_acc >> sh;
      f = '0;
      for (int i = 0; i < 32; i++)
         if (i >= lo && i <= hi) f[i] = v[i];
      return m_base[l] + f;
   endfunction

   function automatic logic [31:0] exp_read(input int a);
      case (a)
         0: return m_acc;
         1: return {17'd0, m_ctrl[0]};
         2: return {17'd0, m_ctrl[1]};
         3: return m_base[0];
         4: return m_base[1];
         5: return exp_peek(0);
         6: return exp_peek(1);
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_write(input int a, input logic [31:0] d);
      case (a)
         0: m_acc = d;
         1: m_ctrl[0] = d[14:0];
         2: m_ctrl[1] = d[14:0];
         3: m_base[0] = d;
         4: m_base[1] = d;
         default: ;
      endcase
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wdata = d;
      @(posedge clk);
      model_write(a, d);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input int a);
      @(negedge clk);
      rd_addr = 3'(a);
      #1 check(req, rdata, exp_read(a));
   endtask

   task automatic rd_lit(input string req, input int a, input logic [31:0] exp);
      @(negedge clk);
      rd_addr = 3'(a);
      #1 check(req, rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] keep;
      void'($urandom(32'd20240611));
      m_acc = '0; m_ctrl[0] = '0; m_ctrl[1] = '0; m_base[0] = '0; m_base[1] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every location reads zero after reset
      for (int a = 0; a < 8; a++) rd_lit("R1", a, 32'd0);

      // R2: accumulator write and readback
      do_write(0, 32'hDEAD_BEEF);
      rd_lit("R2", 0, 32'hDEAD_BEEF);

      // R3: control layout, upper bits dropped
      do_write(1, 32'hFFFF_FFFF);
      rd_lit("R3", 1, 32'h0000_7FFF);
      do_write(2, 32'h1234_5678);
      rd_lit("R3", 2, 32'h0000_5678);

      // R4: base registers
      do_write(3, 32'h2000_0100);
      do_write(4, 32'h2000_0800);
      rd_lit("R4", 3, 32'h2000_0100);
      rd_lit("R4", 4, 32'h2000_0800);

      // R5: two 16-bit pixels, low 5 bits of each
      do_write(0, 32'hABCD_1234);
      do_write(1, {17'd0, 5'd4, 5'd0, 5'd0});   // shift 0, bits 0..4
      do_write(2, {17'd0, 5'd4, 5'd0, 5'd16});  // shift 16, bits 0..4
      rd_lit("R5", 5, 32'h2000_0100 + 32'h14);
      rd_lit("R5", 6, 32'h2000_0800 + 32'h0D);
      // R5: 8-bit pixels 2 and 3 of a word, 3 bits pre-scaled
      do_write(0, 32'h5A3C_0000);
      do_write(1, {17'd0, 5'd10, 5'd3, 5'd16});
      do_write(2, {17'd0, 5'd10, 5'd3, 5'd24});
      rd("R5", 5);
      rd("R5", 6);

      // R6: right shift only, no wrap
      do_write(3, 32'd0);
      do_write(0, 32'h8000_0001);
      do_write(1, {17'd0, 5'd31, 5'd0, 5'd31});
      rd_lit("R6", 5, 32'h0000_0001);
      do_write(1, {17'd0, 5'd31, 5'd0, 5'd1});
      rd_lit("R6", 5, 32'h4000_0000);

      // R7: high index below low index gives base
      do_write(4, 32'h3000_0040);
      do_write(0, 32'hFFFF_FFFF);
      do_write(2, {17'd0, 5'd3, 5'd7, 5'd0});
      rd_lit("R7", 6, 32'h3000_0040);

      // R11: base addition wraps
      do_write(3, 32'hFFFF_FFF0);
      do_write(0, 32'h0000_0020);
      do_write(1, {17'd0, 5'd31, 5'd0, 5'd0});
      rd_lit("R11", 5, 32'h0000_0010);

      // R8: repeated peek reads change nothing
      keep = exp_read(5);
      for (int k = 0; k < 4; k++) rd_lit("R8", 5, keep);
      rd_lit("R8", 0, 32'h0000_0020);
      rd_lit("R8", 3, 32'hFFFF_FFF0);

      // R9: peek in the write cycle sees old word, next cycle new word
      begin
         logic [31:0] old_v;
         old_v = exp_read(5);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 3'd0; wdata = 32'h0000_0100; rd_addr = 3'd5;
         #1 check("R9", rdata, old_v);
         @(posedge clk);
         model_write(0, 32'h0000_0100);
         #1 wr_en = 1'b0;
         #2 check("R9", rdata, exp_read(5));
      end

      // R10: writes to peek and unmapped addresses ignored
      do_write(5, 32'h1111_1111);
      do_write(6, 32'h2222_2222);
      do_write(7, 32'h3333_3333);
      for (int a = 0; a < 8; a++) rd("R10", a);

      // Random mix of writes and reads against the model (R5, R9)
      for (int n = 0; n < 600; n++) begin
         int a;
         logic [31:0] d;
         a = int'($urandom % 8);
         d = $urandom;
         if ($urandom % 2 == 0) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 3'(a); wdata = d;
            rd_addr = 3'(5 + ($urandom % 2));
            #1 check("R9", rdata, exp_read(int'(rd_addr)));
            @(posedge clk);
            model_write(a, d);
            #1 wr_en = 1'b0;
         end else begin
            rd("R5", a);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule